// File: doc/BRIEF.md
# External Memory Bus Interface Controller

This block sits between the core of a small 8-bit microcontroller and its memory. The core hands it one request at a time: an instruction-byte fetch, a MOVX read or a MOVX write, with a 16-bit address. The block sends the request to one of four targets. One target is the 8 KB on-chip extension RAM. The other three are off-chip 64 KB regions, and each of these has its own active-low chip select. It then runs the bus cycle for that target and returns a one-cycle ready pulse, together with the read byte when the request was a read.

A control register in special-function space sets how requests are routed. It picks the target of MOVX reads and, separately, the target of MOVX writes. It has separate stretch enables for reads and writes, an overlay of the low 8 KB of program space onto the on-chip RAM, and a bus-hold request. A static strap input chooses the pin arrangement. In separate mode, the full address is driven on A15..A0 and data uses D7..D0. In shared mode, the low address byte and the data share A7..A0, and D7 carries an address-latch strobe. Pins are modelled as separate output, output-enable and input vectors.

Top module: `xbus_ctrl`

## Requirements
- R1: After reset the control register reads 0x00, all three chip selects, the output enable and the write enable are high (inactive), ready is low, and no data pin is driven.
- R2: The control register answers only at address 0xFA: a write there updates it and a read there returns it. A write to any other address leaves it unchanged, and a read elsewhere returns 0x00.
- R3: Fetches (kind 00) go to chip select 1. When control bit 6 is set, fetches below 0x2000 go to the on-chip RAM instead and make no off-chip access. Fetches at 0x2000 and above still use chip select 1.
- R4: MOVX reads (kind 01, and kind 11, which behaves the same) go to the target in control bits 1:0. The encoding is 00 on-chip RAM, 01 chip select 1, 10 chip select 2, 11 chip select 3. The byte read is returned with ready.
- R5: MOVX writes (kind 10) go to the target in control bits 4:3, with the same encoding, and carry the request's data byte to that target.
- R6: An off-chip access holds its strobe (output enable for reads, write enable for writes) low for 2 cycles. It holds it for 4 cycles when stretched. Bit 2 stretches MOVX reads only, bit 5 stretches MOVX writes only, and fetches are never stretched.
- R7: At most one chip select is low at any time, and only during an off-chip access. Output enable and write enable are never low together.
- R8: An access to the on-chip RAM lowers no chip select, output enable or write enable, and drives no data pin. It takes one RAM cycle.
- R9: With the strap low, the address appears on A15..A0, write data is driven on D7..D0 only during the write strobe, and no address-latch pulse occurs.
- R10: With the strap high, each off-chip access starts with exactly one cycle in which D7 is high and A7..A0 carry the low address byte. After that, A7..A0 carry data: they are driven with write data during a write and released during a read.
- R11: With the strap high, no address-latch pulse occurs for an access to the on-chip RAM or while idle.
- R12: Ready is high for exactly one cycle per request.
- R13: With control bit 7 set, the keeper request is raised on the data pins in use: D7..D0 with the strap low, A7..A0 with the strap high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mux_sel | input | 1 | Strap: 1 = shared address/data pins, 0 = separate |
| sfr_we | input | 1 | Special-function register write strobe |
| sfr_addr | input | 8 | Special-function register address |
| sfr_wdata | input | 8 | Special-function register write data |
| sfr_rdata | output | 8 | Control register value when addressed, else 0 |
| req_valid | input | 1 | Request present (taken only while idle) |
| req_kind | input | 2 | 00 fetch, 01 MOVX read, 10 MOVX write, 11 MOVX read |
| req_addr | input | 16 | Request address |
| req_wdata | input | 8 | MOVX write data |
| req_ready | output | 1 | One-cycle completion pulse |
| req_rdata | output | 8 | Read byte, valid with ready |
| ram_en | output | 1 | On-chip RAM access cycle |
| ram_we | output | 1 | On-chip RAM write |
| ram_addr | output | 13 | On-chip RAM byte address |
| ram_wdata | output | 8 | On-chip RAM write data |
| ram_rdata | input | 8 | On-chip RAM read data |
| cs_n | output | 3 | Active-low chip selects for regions 1..3 (bit 0 = region 1) |
| oe_n | output | 1 | Active-low output enable |
| we_n | output | 1 | Active-low write enable |
| a_hi_o | output | 8 | Address pins A15..A8 |
| a_lo_o | output | 8 | Pins A7..A0 output value |
| a_lo_oe | output | 1 | Pins A7..A0 drive enable |
| a_lo_i | input | 8 | Pins A7..A0 input value |
| d_o | output | 8 | Pins D7..D0 output value (D7 = address latch strobe in shared mode) |
| d_oe | output | 8 | Per-pin drive enable for D7..D0 |
| d_i | input | 8 | Pins D7..D0 input value |
| keep_a_lo | output | 1 | Keeper request for A7..A0 |
| keep_d | output | 1 | Keeper request for D7..D0 |

## Verification
On every cycle, the assertions check the bus-safety rules: one chip select at most, never both strobes together, and a quiet bus during RAM cycles. They also check that an address-latch pulse is followed at once by a strobe and only happens for off-chip targets, that every strobe run is 2 or 4 cycles, and that ready lasts one cycle. The routing cannot be seen from any one cycle, so it is left to the bench scenarios: which region a given kind, address and control setting reaches, whether stretching follows the right bit, and whether the right byte crosses the bus in both pin arrangements. The bench's device model returns address-dependent data and records writes, so these scenarios compare real bytes end to end.

// File: rtl/xbus_pkg.sv
package xbus_pkg;

  typedef enum logic [1:0] {
    K_FETCH = 2'd0,
    K_READ  = 2'd1,
    K_WRITE = 2'd2,
    K_READ2 = 2'd3
  } kind_e;

  // control register, msb first; field positions are decoded below
  typedef struct packed {
    logic       hold;
    logic       ovl;
    logic       wr_long;
    logic [1:0] wr_tgt;
    logic       rd_long;
    logic [1:0] rd_tgt;
  } ctl_t;

  localparam logic [1:0] TGT_RAM = 2'd0;
  localparam logic [1:0] TGT_CS1 = 2'd1;

  function automatic logic [1:0] pick_target(kind_e k, logic [15:0] a, ctl_t c,
                                             int unsigned ovl_bytes);
    case (k)
      K_FETCH: return (c.ovl && (32'(a) < ovl_bytes)) ? TGT_RAM : TGT_CS1;
      K_WRITE: return c.wr_tgt;
      default: return c.rd_tgt;
    endcase
  endfunction

  function automatic logic want_long(kind_e k, ctl_t c);
    case (k)
      K_FETCH: return 1'b0;
      K_WRITE: return c.wr_long;
      default: return c.rd_long;
    endcase
  endfunction

endpackage

// File: rtl/xbus_cfg_reg.sv
module xbus_cfg_reg
  import xbus_pkg::*;
#(
  parameter logic [7:0] REG_ADDR = 8'hFA
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic [7:0] addr,
  input  logic [7:0] wdata,
  output logic [7:0] rdata,
  output ctl_t       ctl
);
  logic hit;
  assign hit = (addr == REG_ADDR);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            ctl <= '0;
    else if (wr_en && hit) ctl <= ctl_t'(wdata);
  end

  assign rdata = hit ? 8'(ctl) : 8'h00;

  a_r2_foreign_write_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !hit) |=> $stable(ctl));
endmodule

// File: rtl/xbus_route.sv
module xbus_route
  import xbus_pkg::*;
#(
  parameter int unsigned OVL_BYTES = 8192
) (
  input  kind_e       kind,
  input  logic [15:0] addr,
  input  ctl_t        ctl,
  output logic [1:0]  tgt,
  output logic        stretch
);
  assign tgt     = pick_target(kind, addr, ctl, OVL_BYTES);
  assign stretch = want_long(kind, ctl);
endmodule

// File: rtl/xbus_seq.sv
module xbus_seq #(
  parameter int BASE_LEN  = 2,
  parameter int EXTRA_LEN = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic [1:0] tgt,
  input  logic       stretch,
  input  logic       mux,
  output logic       idle,
  output logic       ram_ph,
  output logic       ale_ph,
  output logic       strb_ph,
  output logic       strb_last,
  output logic       done_ph
);
  localparam int LONG_LEN = BASE_LEN + EXTRA_LEN;
  localparam int CW       = $clog2(LONG_LEN + 1);

  typedef enum logic [2:0] {S_IDLE, S_RAM, S_ALE, S_STRB, S_DONE} st_e;
  st_e           st;
  logic [CW-1:0] cnt, len_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st    <= S_IDLE;
      cnt   <= '0;
      len_q <= '0;
    end else begin
      case (st)
        S_IDLE: if (start) begin
          cnt   <= '0;
          len_q <= stretch ? CW'(LONG_LEN) : CW'(BASE_LEN);
          if (tgt == 2'd0) st <= S_RAM;
          else             st <= mux ? S_ALE : S_STRB;
        end
        S_RAM:  st <= S_DONE;
        S_ALE:  st <= S_STRB;
        S_STRB: begin
          cnt <= cnt + 1'b1;
          if (strb_last) st <= S_DONE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  assign idle      = (st == S_IDLE);
  assign ram_ph    = (st == S_RAM);
  assign ale_ph    = (st == S_ALE);
  assign strb_ph   = (st == S_STRB);
  assign done_ph   = (st == S_DONE);
  assign strb_last = strb_ph && (cnt == len_q - 1'b1);

  // checker: length of each strobe run, counted independently of cnt
  logic [CW:0] run;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       run <= '0;
    else if (strb_ph) run <= run + 1'b1;
    else              run <= '0;
  end

  a_r6_strobe_run_len: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(strb_ph) |-> (run == (CW+1)'(BASE_LEN) || run == (CW+1)'(LONG_LEN)));
  a_r10_ale_then_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    ale_ph |=> strb_ph);
  a_r12_done_returns_idle: assert property (@(posedge clk) disable iff (!rst_n)
    done_ph |=> idle);
endmodule

// File: rtl/xbus_ctrl.sv
module xbus_ctrl
  import xbus_pkg::*;
#(
  parameter int         RAM_AW    = 13,
  parameter logic [7:0] CFG_ADDR  = 8'hFA,
  parameter int         BASE_LEN  = 2,
  parameter int         EXTRA_LEN = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mux_sel,
  input  logic              sfr_we,
  input  logic [7:0]        sfr_addr,
  input  logic [7:0]        sfr_wdata,
  output logic [7:0]        sfr_rdata,
  input  logic              req_valid,
  input  logic [1:0]        req_kind,
  input  logic [15:0]       req_addr,
  input  logic [7:0]        req_wdata,
  output logic              req_ready,
  output logic [7:0]        req_rdata,
  output logic              ram_en,
  output logic              ram_we,
  output logic [RAM_AW-1:0] ram_addr,
  output logic [7:0]        ram_wdata,
  input  logic [7:0]        ram_rdata,
  output logic [2:0]        cs_n,
  output logic              oe_n,
  output logic              we_n,
  output logic [7:0]        a_hi_o,
  output logic [7:0]        a_lo_o,
  output logic              a_lo_oe,
  input  logic [7:0]        a_lo_i,
  output logic [7:0]        d_o,
  output logic [7:0]        d_oe,
  input  logic [7:0]        d_i,
  output logic              keep_a_lo,
  output logic              keep_d
);
  localparam int unsigned OVL_BYTES = 1 << RAM_AW;

  ctl_t       ctl;
  logic [1:0] dec_tgt;
  logic       dec_long;
  logic       idle, ram_ph, ale_ph, strb_ph, strb_last, done_ph, start;

  logic [15:0] lat_addr;
  logic [7:0]  lat_wdata, rd_q;
  logic [1:0]  lat_tgt;
  logic        lat_wr;

  xbus_cfg_reg #(.REG_ADDR(CFG_ADDR)) u_cfg (
    .clk(clk), .rst_n(rst_n), .wr_en(sfr_we), .addr(sfr_addr),
    .wdata(sfr_wdata), .rdata(sfr_rdata), .ctl(ctl));

  xbus_route #(.OVL_BYTES(OVL_BYTES)) u_route (
    .kind(kind_e'(req_kind)), .addr(req_addr), .ctl(ctl),
    .tgt(dec_tgt), .stretch(dec_long));

  assign start = req_valid && idle;

  xbus_seq #(.BASE_LEN(BASE_LEN), .EXTRA_LEN(EXTRA_LEN)) u_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .tgt(dec_tgt),
    .stretch(dec_long), .mux(mux_sel), .idle(idle), .ram_ph(ram_ph),
    .ale_ph(ale_ph), .strb_ph(strb_ph), .strb_last(strb_last),
    .done_ph(done_ph));

  // request capture and read-data return
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lat_addr  <= '0;
      lat_wdata <= '0;
      lat_tgt   <= '0;
      lat_wr    <= 1'b0;
      rd_q      <= '0;
    end else begin
      if (start) begin
        lat_addr  <= req_addr;
        lat_wdata <= req_wdata;
        lat_tgt   <= dec_tgt;
        lat_wr    <= (kind_e'(req_kind) == K_WRITE);
      end
      if (ram_ph && !lat_wr)                rd_q <= ram_rdata;
      else if (strb_last && !lat_wr)        rd_q <= mux_sel ? a_lo_i : d_i;
    end
  end

  assign req_ready = done_ph;
  assign req_rdata = rd_q;

  assign ram_en    = ram_ph;
  assign ram_we    = ram_ph && lat_wr;
  assign ram_addr  = lat_addr[RAM_AW-1:0];
  assign ram_wdata = lat_wdata;

  // chip selects, one per off-chip region
  logic bus_busy;
  assign bus_busy = ale_ph || strb_ph;
  for (genvar gi = 0; gi < 3; gi++) begin : g_cs
    assign cs_n[gi] = !(bus_busy && (lat_tgt == 2'(gi + 1)));
  end

  assign oe_n   = !(strb_ph && !lat_wr);
  assign we_n   = !(strb_ph && lat_wr);
  assign a_hi_o = lat_addr[15:8];

  logic wr_drive;
  assign wr_drive = strb_ph && lat_wr;

  always_comb begin
    if (mux_sel) begin
      a_lo_o  = ale_ph ? lat_addr[7:0] : lat_wdata;
      a_lo_oe = ale_ph || wr_drive;
      d_o     = {ale_ph, 7'b0};
      d_oe    = 8'h80;
    end else begin
      a_lo_o  = lat_addr[7:0];
      a_lo_oe = 1'b1;
      d_o     = lat_wdata;
      d_oe    = {8{wr_drive}};
    end
  end

  assign keep_a_lo = ctl.hold && mux_sel;
  assign keep_d    = ctl.hold && !mux_sel;

  a_r7_one_select: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(~cs_n));
  a_r7_strobes_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(!oe_n && !we_n));
  a_r7_strobe_has_select: assert property (@(posedge clk) disable iff (!rst_n)
    (!oe_n || !we_n) |-> (cs_n != 3'b111));
  a_r8_ram_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    ram_en |-> (cs_n == 3'b111 && oe_n && we_n && (mux_sel ? !a_lo_oe : d_oe == 8'h00)));
  a_r9_no_latch_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    !mux_sel |-> !ale_ph);
  a_r11_latch_only_offchip: assert property (@(posedge clk) disable iff (!rst_n)
    ale_ph |-> (cs_n != 3'b111 && a_lo_oe));
  a_r12_ready_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |=> !req_ready);
endmodule

// File: tb/tb_xbus_ctrl.sv
module tb_xbus_ctrl;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic        mux_sel = 1'b0;
  logic        sfr_we = 1'b0;
  logic [7:0]  sfr_addr = 8'h00, sfr_wdata = 8'h00, sfr_rdata;
  logic        req_valid = 1'b0;
  logic [1:0]  req_kind = 2'd0;
  logic [15:0] req_addr = 16'h0;
  logic [7:0]  req_wdata = 8'h00, req_rdata;
  logic        req_ready;
  logic        ram_en, ram_we;
  logic [12:0] ram_addr;
  logic [7:0]  ram_wdata, ram_rdata;
  logic [2:0]  cs_n;
  logic        oe_n, we_n, a_lo_oe, keep_a_lo, keep_d;
  logic [7:0]  a_hi_o, a_lo_o, a_lo_i, d_o, d_oe, d_i;

  xbus_ctrl dut (
    .clk(clk), .rst_n(rst_n), .mux_sel(mux_sel), .sfr_we(sfr_we),
    .sfr_addr(sfr_addr), .sfr_wdata(sfr_wdata), .sfr_rdata(sfr_rdata),
    .req_valid(req_valid), .req_kind(req_kind), .req_addr(req_addr),
    .req_wdata(req_wdata), .req_ready(req_ready), .req_rdata(req_rdata),
    .ram_en(ram_en), .ram_we(ram_we), .ram_addr(ram_addr),
    .ram_wdata(ram_wdata), .ram_rdata(ram_rdata), .cs_n(cs_n),
    .oe_n(oe_n), .we_n(we_n), .a_hi_o(a_hi_o), .a_lo_o(a_lo_o),
    .a_lo_oe(a_lo_oe), .a_lo_i(a_lo_i), .d_o(d_o), .d_oe(d_oe), .d_i(d_i),
    .keep_a_lo(keep_a_lo), .keep_d(keep_d));

  int n_checks = 0, n_fail = 0;
  logic [7:0] cfg_sh = 8'h00;

  // device contents: a byte pattern from region and address
  function automatic logic [7:0] pat(int region, logic [15:0] a);
    return a[7:0] + 8'(a[15:8] * 3) + 8'(region * 8'h5A);
  endfunction

  // external device and RAM model
  logic [7:0]  dev_lat = 8'h00;
  int          dev_region;
  logic [15:0] dev_addr;
  always_comb begin
    case (cs_n)
      3'b110:  dev_region = 1;
      3'b101:  dev_region = 2;
      3'b011:  dev_region = 3;
      default: dev_region = 0;
    endcase
  end
  assign dev_addr  = mux_sel ? {a_hi_o, dev_lat} : {a_hi_o, a_lo_o};
  assign d_i       = (!oe_n && !mux_sel) ? pat(dev_region, dev_addr) : 8'h00;
  assign a_lo_i    = (!oe_n && mux_sel)  ? pat(dev_region, dev_addr) : 8'h00;
  assign ram_rdata = pat(0, {3'b000, ram_addr});

  int          wr_region = -1;
  logic [15:0] wr_addr = 16'h0;
  logic [7:0]  wr_data = 8'h00;
  always @(negedge clk) begin
    if (mux_sel && d_oe[7] && d_o[7]) dev_lat <= a_lo_o;
    if (!we_n) begin
      wr_region <= dev_region;
      wr_addr   <= dev_addr;
      wr_data   <= mux_sel ? a_lo_o : d_o;
    end else if (ram_en && ram_we) begin
      wr_region <= 0;
      wr_addr   <= {3'b000, ram_addr};
      wr_data   <= ram_wdata;
    end
  end

  typedef struct {
    string       tag;
    int          tgt, strb, ale, ram, drv, cs;
    logic        is_rd;
    logic [7:0]  rd;
    logic [15:0] waddr;
    logic [7:0]  wdat;
  } exp_t;
  exp_t q[$];

  task automatic check(string req, logic ok, string detail);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: %s", req, detail);
    end
  endtask

  // driver: predict, push, issue
  task automatic acc(string tag, logic [1:0] kind, logic [15:0] a, logic [7:0] wd);
    exp_t e;
    logic lng;
    e.tag = tag;
    if (kind == 2'd0)      e.tgt = (cfg_sh[6] && a < 16'h2000) ? 0 : 1;
    else if (kind == 2'd2) e.tgt = int'(cfg_sh[4:3]);
    else                   e.tgt = int'(cfg_sh[1:0]);
    lng = (kind == 2'd2) ? cfg_sh[5] : (kind == 2'd0) ? 1'b0 : cfg_sh[2];
    e.strb  = (e.tgt == 0) ? 0 : (lng ? 4 : 2);
    e.ale   = (mux_sel && e.tgt != 0) ? 1 : 0;
    e.ram   = (e.tgt == 0) ? 1 : 0;
    e.cs    = e.strb + e.ale;
    e.is_rd = (kind != 2'd2);
    e.drv   = e.is_rd ? 0 : e.strb;
    e.waddr = (e.tgt == 0) ? {3'b000, a[12:0]} : a;
    e.wdat  = wd;
    e.rd    = pat(e.tgt, e.waddr);
    q.push_back(e);
    @(negedge clk);
    req_valid = 1'b1; req_kind = kind; req_addr = a; req_wdata = wd;
    @(negedge clk);
    req_valid = 1'b0;
    wait (q.size() == 0);
    @(negedge clk);
  endtask

  task automatic cfg_write(logic [7:0] a, logic [7:0] v);
    @(negedge clk);
    sfr_we = 1'b1; sfr_addr = a; sfr_wdata = v;
    @(negedge clk);
    sfr_we = 1'b0; sfr_addr = 8'hFA;
    if (a == 8'hFA) cfg_sh = v;
  endtask

  // monitor: accumulate pin activity, compare on each ready
  int n_cs = 0, n_strb = 0, n_ale = 0, n_ram = 0, n_drv = 0, obs_tgt = 0;
  logic prev_ready = 1'b0;
  always @(negedge clk) begin
    if (rst_n) begin
      if (cs_n != 3'b111) begin n_cs++; obs_tgt = dev_region; end
      if (!oe_n || !we_n) n_strb++;
      if (mux_sel && d_oe[7] && d_o[7]) n_ale++;
      if (ram_en) n_ram++;
      if (mux_sel ? (a_lo_oe && !d_o[7]) : (d_oe != 8'h00)) n_drv++;
      if (req_ready && prev_ready)
        check("R12", 1'b0, "ready high for two cycles");
      if (req_ready && !prev_ready) begin
        if (q.size() == 0) check("R12", 1'b0, "ready with no request");
        else begin
          exp_t e;
          logic ok;
          e = q.pop_front();
          ok = obs_tgt == e.tgt && n_strb == e.strb && n_ale == e.ale &&
               n_ram == e.ram && n_drv == e.drv && n_cs == e.cs;
          if (e.is_rd) ok = ok && (req_rdata == e.rd);
          else ok = ok && wr_region == e.tgt && wr_addr == e.waddr && wr_data == e.wdat;
          check(e.tag, ok, $sformatf(
            "act tgt=%0d strb=%0d ale=%0d ram=%0d drv=%0d cs=%0d rd=%h w=%0d/%h/%h exp tgt=%0d strb=%0d ale=%0d ram=%0d drv=%0d cs=%0d rd=%h w=%h/%h",
            obs_tgt, n_strb, n_ale, n_ram, n_drv, n_cs, req_rdata, wr_region, wr_addr, wr_data,
            e.tgt, e.strb, e.ale, e.ram, e.drv, e.cs, e.rd, e.waddr, e.wdat));
        end
        n_cs = 0; n_strb = 0; n_ale = 0; n_ram = 0; n_drv = 0; obs_tgt = 0;
      end
      prev_ready = req_ready;
    end
  end

  logic finished = 1'b0;
  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      check("watchdog", 1'b0, "run did not complete");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    sfr_addr = 8'hFA;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: idle state after reset
    check("R1", sfr_rdata == 8'h00, $sformatf("cfg act %h exp 00", sfr_rdata));
    check("R1", cs_n == 3'b111 && oe_n && we_n && !req_ready && d_oe == 8'h00,
          $sformatf("cs_n=%b oe_n=%b we_n=%b rdy=%b d_oe=%h exp 111 1 1 0 00",
                    cs_n, oe_n, we_n, req_ready, d_oe));

    // R2: only address 0xFA reaches the register
    cfg_write(8'hFB, 8'hFF);
    check("R2", sfr_rdata == 8'h00, $sformatf("after foreign write act %h exp 00", sfr_rdata));
    cfg_write(8'hFA, 8'h1A);
    check("R2", sfr_rdata == 8'h1A, $sformatf("readback act %h exp 1a", sfr_rdata));
    sfr_addr = 8'h10;
    #1 check("R2", sfr_rdata == 8'h00, $sformatf("other addr read act %h exp 00", sfr_rdata));
    sfr_addr = 8'hFA;

    // separate pins, cfg 0x1A: reads CS2, writes CS3
    acc("R4 read to region 2 (R9)", 2'd1, 16'hBEEF, 8'h00);
    acc("R5 write to region 3 (R9, R7)", 2'd2, 16'h1357, 8'h3C);
    acc("R3 fetch default region 1", 2'd0, 16'h0100, 8'h00);

    cfg_write(8'hFA, 8'h00);
    acc("R4 read to on-chip RAM (R8)", 2'd1, 16'h0456, 8'h00);
    acc("R5 write to on-chip RAM (R8)", 2'd2, 16'h3456, 8'hA5);
    acc("R3 fetch low without overlay", 2'd0, 16'h1234, 8'h00);

    // overlay, read region 1 stretched
    cfg_write(8'hFA, 8'h45);
    acc("R3 overlay fetch 0x1FFF to RAM", 2'd0, 16'h1FFF, 8'h00);
    acc("R3 overlay fetch 0x2000 to region 1", 2'd0, 16'h2000, 8'h00);
    acc("R6 stretched read region 1", 2'd1, 16'h8001, 8'h00);
    acc("R4 kind 11 acts as read", 2'd3, 16'h0042, 8'h00);
    acc("R6 fetch never stretched", 2'd0, 16'hC000, 8'h00);

    // write stretch to region 2, read back to RAM unstretched
    cfg_write(8'hFA, 8'h30);
    acc("R6 stretched write region 2", 2'd2, 16'h4444, 8'h81);
    acc("R6 read not stretched by write bit", 2'd1, 16'h0777, 8'h00);

    // R13: keepers with separate pins
    cfg_write(8'hFA, 8'h80);
    check("R13", keep_d && !keep_a_lo, $sformatf("keep_d=%b keep_a_lo=%b exp 1 0", keep_d, keep_a_lo));

    // shared pins
    mux_sel = 1'b1;
    @(negedge clk);
    check("R13", !keep_d && keep_a_lo, $sformatf("keep_d=%b keep_a_lo=%b exp 0 1", keep_d, keep_a_lo));
    check("R11", d_oe == 8'h80 && !d_o[7], $sformatf("idle d_oe=%h d7=%b exp 80 0", d_oe, d_o[7]));
    cfg_write(8'hFA, 8'hB7);
    acc("R10 shared read region 3 stretched", 2'd1, 16'h5AC3, 8'h00);
    acc("R10 shared write region 2 stretched", 2'd2, 16'h77AA, 8'h5E);
    cfg_write(8'hFA, 8'h40);
    acc("R11 shared overlay fetch no latch pulse", 2'd0, 16'h0800, 8'h00);
    acc("R11 shared RAM read no latch pulse", 2'd1, 16'h0123, 8'h00);
    acc("R10 shared fetch region 1", 2'd0, 16'hF00D, 8'h00);
    cfg_write(8'hFA, 8'h00);
    check("R13", !keep_d && !keep_a_lo, $sformatf("keep off act %b%b exp 00", keep_d, keep_a_lo));

    repeat (4) @(negedge clk);
    finished = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule